// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Port

This block moves one byte at a time over a two-wire link: a clock line and a single data line that carries traffic in one direction at a time. As the clock master it derives the serial clock from its own operating clock at one of four rates. As a slave it follows a clock from another device. A direction input chooses whether the data line transmits or receives. The data line is modelled as three signals: output value, output enable and input value. The clock line is modelled the same way.

Control comes in as plain level inputs: enable, master select, direction, clock idle polarity and a two-bit rate code. A one-cycle write strobe with a byte starts a master transfer. A one-cycle read strobe acknowledges the result. A completion flag and a sticky collision flag report progress. The last received byte stays readable on a data output.

Top module: `hdx_sport`

## Requirements
- R1: In master mode the serial clock spends 8, 4, 2 or 1 operating-clock cycles in each level for rate codes 0, 1, 2 and 3. Its period is therefore 16, 8, 4 or 2 cycles, and the first edge comes one half period after the write that starts the transfer.
- R2: While enabled as master and not transferring, `sck_o` equals `cpol_i`. `sck_oe_o` is high exactly when the port is enabled as master.
- R3: `sd_oe_o` is high only when the port is enabled, in master mode and in transmit direction (`dir_tx_i`=1). It is low after reset, while disabled, in slave mode and in receive direction.
- R4: In a master transmit, `sd_o` presents bit 7 of the written byte from the start. It then moves to the next lower bit at each falling `sck_o` edge that follows a rising edge, and it changes at no other time during the transfer.
- R5: In a master receive, `sd_i` is captured at each rising `sck_o` edge, most significant bit first. The assembled byte appears on `rd_data_o` in the same cycle that `done_o` rises.
- R6: `done_o` is low after reset. It rises in the cycle of the eighth rising clock edge of a transfer and falls after a cycle with `rd_en_i` or `wr_en_i` high. When a completion and an access fall in the same cycle, the completion wins.
- R7: A write while a transfer is in progress is ignored: the byte on the line is unchanged. It also sets `wcol_o`, which stays high until a cycle with `rd_en_i` high.
- R8: In slave mode, `sck_i` passes through a two-stage synchronizer. After eight rising edges of `sck_i`, the byte sampled from `sd_i` (MSB first) is on `rd_data_o` and `done_o` is high, at most three operating-clock cycles after the last rising edge.
- R9: A master transfer makes exactly 16 clock edges, 8 of them rising, whatever the polarity, and then leaves `sck_o` at the idle level.
- R10: A transfer in transmit direction leaves `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Port enable |
| master_i | input | 1 | 1 = clock master, 0 = slave |
| dir_tx_i | input | 1 | 1 = transmit, 0 = receive |
| cpol_i | input | 1 | Idle level of the serial clock |
| rate_i | input | 2 | Master clock rate code |
| wr_en_i | input | 1 | Data write strobe (starts a master transfer) |
| wr_data_i | input | 8 | Byte to transmit |
| rd_en_i | input | 1 | Data read strobe (acknowledge) |
| rd_data_o | output | 8 | Last received byte |
| done_o | output | 1 | Transfer complete flag |
| wcol_o | output | 1 | Write collision flag |
| sck_i | input | 1 | Serial clock from the line |
| sck_o | output | 1 | Serial clock driven by the master |
| sck_oe_o | output | 1 | Serial clock output enable |
| sd_i | input | 1 | Serial data from the line |
| sd_o | output | 1 | Serial data driven out |
| sd_oe_o | output | 1 | Serial data output enable |

## Verification
A master transfer starts at the clock edge that captures the write. The first serial clock edge shows one half period later. After that the bench expects one edge per half period, counted in operating cycles. `done_o` and the received byte are due in the same cycle as the eighth rising edge, and the line is idle again one half period after that. In slave mode the completion is due three cycles after the last `sck_i` rise, because of the two synchronizer flops and the edge flop. The bench holds each data bit for four cycles past its rising edge so that the delayed sample still sees it. All outputs are sampled on the falling edge of the operating clock. Edge timing is measured there as a count of cycles since the start write, and each value is compared in the exact cycle the requirement names.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  // Default geometry of the port.
  localparam int HDX_BITS   = 8;
  localparam int HDX_RATE_W = 2;

  // Number of operating-clock cycles per serial-clock level for a rate code.
  // Code 0 is the slowest; each step up halves the level time.
  function automatic int hdx_half_cycles(input int rate_w, input int code);
    return (1 << ((1 << rate_w) - 1)) >> code;
  endfunction

endpackage

// File: rtl/hdx_clkgen.sv
module hdx_clkgen
  import hdx_pkg::*;
#(
  parameter int BITS   = HDX_BITS,
  parameter int RATE_W = HDX_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en_i,
  input  logic              cpol_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              rise_o,
  output logic              fall_o
);

  localparam int MAX_HALF = hdx_half_cycles(RATE_W, 0);
  localparam int DIV_W    = $clog2(MAX_HALF) + 1;
  localparam int EDGES    = 2 * BITS;
  localparam int EDGE_W   = $clog2(EDGES) + 1;

  logic [DIV_W-1:0]  div_q, div_n;
  logic [EDGE_W-1:0] edge_q, edge_n;
  logic              busy_q, busy_n;
  logic              sck_q, sck_n;
  logic [DIV_W-1:0]  half_lim;
  logic              wrap;

  always_comb begin
    half_lim = DIV_W'(hdx_half_cycles(RATE_W, int'(rate_i)) - 1);
    // >= lets a rate change in the middle of a transfer still reach a wrap.
    wrap     = busy_q && (div_q >= half_lim);
    rise_o   = wrap && !sck_q;
    fall_o   = wrap && sck_q;
  end

  always_comb begin
    div_n  = div_q;
    edge_n = edge_q;
    busy_n = busy_q;
    sck_n  = sck_q;
    if (!run_en_i) begin
      div_n  = '0;
      edge_n = '0;
      busy_n = 1'b0;
      sck_n  = cpol_i;
    end else if (!busy_q) begin
      sck_n = cpol_i;
      if (start_i) begin
        busy_n = 1'b1;
        div_n  = '0;
        edge_n = '0;
      end
    end else if (wrap) begin
      div_n  = '0;
      sck_n  = !sck_q;
      edge_n = edge_q + 1'b1;
      if (edge_q == EDGE_W'(EDGES - 1)) begin
        busy_n = 1'b0;
      end
    end else begin
      div_n = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      edge_q <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      div_q  <= div_n;
      edge_q <= edge_n;
      busy_q <= busy_n;
      sck_q  <= sck_n;
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;

endmodule

// File: rtl/hdx_sync_edge.sv
module hdx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic en_i,
  output logic rise_o,
  output logic fall_o
);

  // STAGES flops of synchronizer plus one flop holding the previous level.
  logic [STAGES:0] pipe_q, pipe_n;
  logic            cur_lvl, old_lvl;

  always_comb begin
    pipe_n  = {pipe_q[STAGES-1:0], async_i};
    cur_lvl = pipe_q[STAGES-1];
    old_lvl = pipe_q[STAGES];
    rise_o  = en_i && cur_lvl && !old_lvl;
    fall_o  = en_i && !cur_lvl && old_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_n;
    end
  end

endmodule

// File: rtl/hdx_shifter.sv
module hdx_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            dir_tx_i,
  input  logic            load_i,
  input  logic [BITS-1:0] load_data_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            sd_i,
  input  logic            clr_i,
  output logic            sd_o,
  output logic            mid_o,
  output logic            done_o,
  output logic [BITS-1:0] rx_data_o
);

  localparam int CNT_W = $clog2(BITS);

  logic [BITS-1:0]  sh_q, sh_n;
  logic [BITS-1:0]  rx_q, rx_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic [BITS-1:0]  shifted_in;

  always_comb begin
    shifted_in = {sh_q[BITS-2:0], sd_i};
    sh_n   = sh_q;
    rx_n   = rx_q;
    cnt_n  = cnt_q;
    done_n = done_q && !clr_i;
    if (!en_i) begin
      cnt_n = '0;
    end else if (load_i) begin
      sh_n  = load_data_i;
      cnt_n = '0;
    end else begin
      if (rise_i) begin
        if (!dir_tx_i) begin
          sh_n = shifted_in;
        end
        if (cnt_q == CNT_W'(BITS - 1)) begin
          cnt_n  = '0;
          done_n = 1'b1;
          if (!dir_tx_i) begin
            rx_n = shifted_in;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      // Only a falling edge that follows a capture moves the next bit out.
      if (fall_i && dir_tx_i && (cnt_q != '0)) begin
        sh_n = {sh_q[BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      rx_q   <= rx_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign sd_o      = sh_q[BITS-1];
  assign mid_o     = (cnt_q != '0);
  assign done_o    = done_q;
  assign rx_data_o = rx_q;

endmodule

// File: rtl/hdx_sport.sv
module hdx_sport
  import hdx_pkg::*;
#(
  parameter int BITS        = HDX_BITS,
  parameter int RATE_W      = HDX_RATE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              dir_tx_i,
  input  logic              cpol_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              wr_en_i,
  input  logic [BITS-1:0]   wr_data_i,
  input  logic              rd_en_i,
  output logic [BITS-1:0]   rd_data_o,
  output logic              done_o,
  output logic              wcol_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o
);

  logic mst_en, slv_en;
  logic clk_busy, m_rise, m_fall, m_sck;
  logic s_rise, s_fall;
  logic sh_mid;
  logic busy_any, wr_take, wr_hit, start_m;
  logic sel_rise, sel_fall, access;
  logic wcol_q, wcol_n;

  always_comb begin
    mst_en   = en_i && master_i;
    slv_en   = en_i && !master_i;
    busy_any = master_i ? clk_busy : sh_mid;
    wr_take  = wr_en_i && en_i && !busy_any;
    wr_hit   = wr_en_i && en_i && busy_any;
    start_m  = wr_take && master_i;
    sel_rise = master_i ? m_rise : s_rise;
    sel_fall = master_i ? m_fall : s_fall;
    access   = rd_en_i || wr_en_i;
  end

  hdx_clkgen #(
    .BITS   (BITS),
    .RATE_W (RATE_W)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en_i (mst_en),
    .cpol_i   (cpol_i),
    .rate_i   (rate_i),
    .start_i  (start_m),
    .busy_o   (clk_busy),
    .sck_o    (m_sck),
    .rise_o   (m_rise),
    .fall_o   (m_fall)
  );

  hdx_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sck_i),
    .en_i    (slv_en),
    .rise_o  (s_rise),
    .fall_o  (s_fall)
  );

  hdx_shifter #(
    .BITS (BITS)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .dir_tx_i    (dir_tx_i),
    .load_i      (wr_take),
    .load_data_i (wr_data_i),
    .rise_i      (sel_rise),
    .fall_i      (sel_fall),
    .sd_i        (sd_i),
    .clr_i       (access),
    .sd_o        (sd_o),
    .mid_o       (sh_mid),
    .done_o      (done_o),
    .rx_data_o   (rd_data_o)
  );

  // Collision flag: set wins over the read that clears it.
  always_comb begin
    wcol_n = wcol_q;
    if (rd_en_i) wcol_n = 1'b0;
    if (wr_hit)  wcol_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcol_q <= 1'b0;
    end else begin
      wcol_q <= wcol_n;
    end
  end

  assign wcol_o   = wcol_q;
  assign sck_o    = m_sck;
  assign sck_oe_o = mst_en;
  assign sd_oe_o  = mst_en && dir_tx_i;

endmodule

// File: rtl/hdx_sport_chk.sv
module hdx_sport_chk #(
  parameter int BITS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            dir_tx,
  input logic            cpol,
  input logic            wr_en,
  input logic            rd_en,
  input logic            done,
  input logic            wcol,
  input logic [BITS-1:0] rd_data,
  input logic            sck_o,
  input logic            sck_oe,
  input logic            sd_o,
  input logic            sd_oe,
  input logic            busy,
  input logic            rise
);

  // R2: idle master clock sits at the polarity level
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !busy && $past(sck_oe && !busy) && $stable(cpol)) |-> (sck_o == cpol));

  // R3: data driver only alongside the clock driver
  assert_sd_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (sck_oe && en));

  // R4: transmitted data moves only on a falling clock edge or a load
  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && $past(sd_oe) && !$past(wr_en) && !$fell(sck_o)) |-> $stable(sd_o));

  // R6: completion follows a rising sampling edge
  assert_done_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rise));

  // R6: completion clears only after an access
  assert_done_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(rd_en || wr_en));

  // R7: collision flag only from an enabled write
  assert_wcol_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(wr_en && en));

  // R10: received byte changes only on a receive-direction completion
  assert_rx_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(rise && !dir_tx));

endmodule

bind hdx_sport hdx_sport_chk #(.BITS(BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en_i),
  .dir_tx  (dir_tx_i),
  .cpol    (cpol_i),
  .wr_en   (wr_en_i),
  .rd_en   (rd_en_i),
  .done    (done_o),
  .wcol    (wcol_o),
  .rd_data (rd_data_o),
  .sck_o   (sck_o),
  .sck_oe  (sck_oe_o),
  .sd_o    (sd_o),
  .sd_oe   (sd_oe_o),
  .busy    (clk_busy),
  .rise    (sel_rise)
);

// File: tb/hdx_sport_tb.sv
module hdx_sport_tb;

  logic       clk;
  logic       rst_n;
  logic       en_i, master_i, dir_tx_i, cpol_i;
  logic [1:0] rate_i;
  logic       wr_en_i, rd_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic       done_o, wcol_o;
  logic       sck_i, sck_o, sck_oe_o;
  logic       sd_i, sd_o, sd_oe_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] last_rx = 8'h00;

  hdx_sport u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .master_i  (master_i),
    .dir_tx_i  (dir_tx_i),
    .cpol_i    (cpol_i),
    .rate_i    (rate_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .done_o    (done_o),
    .wcol_o    (wcol_o),
    .sck_i     (sck_i),
    .sck_o     (sck_o),
    .sck_oe_o  (sck_oe_o),
    .sd_i      (sd_i),
    .sd_o      (sd_o),
    .sd_oe_o   (sd_oe_o)
  );

  initial clk = 1'b0;
  always #2 clk = !clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not end act=%0d exp<%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] r);
    return 8 >> r;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack();
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    chk(done_o == 1'b0, "R6 done cleared by read", int'(done_o), 0);
    chk(wcol_o == 1'b0, "R7 wcol cleared by read", int'(wcol_o), 0);
  endtask

  task automatic master_xfer(input logic [1:0] rate, input logic pol, input logic dtx,
                             input logic [7:0] tx, input logic [7:0] rx, input bit collide);
    int  h, n, edges, rises;
    bit  rate_ok, hold_ok, tx_ok;
    logic prev_sck, prev_sdo;
    h = half_of(rate);
    en_i = 1'b1; master_i = 1'b1; dir_tx_i = dtx; cpol_i = pol; rate_i = rate;
    idle(3);
    chk(sck_o == pol, "R2 idle level before transfer", int'(sck_o), int'(pol));
    chk(sck_oe_o == 1'b1, "R2 clock driven as master", int'(sck_oe_o), 1);
    chk(sd_oe_o == dtx, "R3 data enable follows direction", int'(sd_oe_o), int'(dtx));
    sd_i = rx[7];
    wr_data_i = tx;
    wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (dtx) chk(sd_o == tx[7], "R4 MSB presented at start", int'(sd_o), int'(tx[7]));
    n = 0; edges = 0; rises = 0;
    rate_ok = 1'b1; hold_ok = 1'b1; tx_ok = 1'b1;
    prev_sck = sck_o; prev_sdo = sd_o;
    while (edges < 16 && n < 400) begin
      @(negedge clk);
      wr_en_i = 1'b0;
      n++;
      if (sck_o != prev_sck) begin
        edges++;
        if (n != edges * h) rate_ok = 1'b0;
        if (sck_o) begin
          rises++;
          if (dtx && sd_o != tx[8 - rises]) tx_ok = 1'b0;
          if (rises == 7) chk(done_o == 1'b0, "R6 done low before 8th rise", int'(done_o), 0);
          if (rises == 8) chk(done_o == 1'b1, "R6 done with 8th rise", int'(done_o), 1);
          if (collide && rises == 3) begin
            wr_data_i = ~tx;
            wr_en_i = 1'b1;
          end
        end else if (rises < 8) begin
          sd_i = rx[7 - rises];
        end
      end else if (dtx && sd_o != prev_sdo) begin
        hold_ok = 1'b0;
      end
      prev_sck = sck_o;
      prev_sdo = sd_o;
    end
    chk(rate_ok, "R1 edge spacing for rate code", n, 16 * h);
    chk(edges == 16 && rises == 8, "R9 edge count", edges * 256 + rises, 16 * 256 + 8);
    if (dtx) begin
      chk(tx_ok, "R4 bits MSB first at rising edges", int'(tx), int'(tx));
      chk(hold_ok, "R4 data changes only at falling edges", 0, 1);
      chk(rd_data_o == last_rx, "R10 transmit keeps rx data", int'(rd_data_o), int'(last_rx));
    end else begin
      chk(rd_data_o == rx, "R5 received byte", int'(rd_data_o), int'(rx));
      last_rx = rx;
    end
    idle(h + 2);
    chk(sck_o == pol, "R9 clock back at idle", int'(sck_o), int'(pol));
    if (collide) chk(wcol_o == 1'b1, "R7 collision flagged", int'(wcol_o), 1);
    ack();
  endtask

  task automatic slave_rx(input logic pol, input logic dtx, input logic [7:0] rx);
    en_i = 1'b0; master_i = 1'b0; cpol_i = pol; dir_tx_i = dtx;
    sck_i = pol;
    idle(5);
    en_i = 1'b1;
    idle(2);
    chk(sd_oe_o == 1'b0, "R3 no data drive as slave", int'(sd_oe_o), 0);
    chk(sck_oe_o == 1'b0, "R2 no clock drive as slave", int'(sck_oe_o), 0);
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b0;
      sd_i = rx[7 - k];
      idle(4);
      sck_i = 1'b1;
      if (k == 7) begin
        idle(3);
        chk(done_o == 1'b1, "R8 slave done three cycles after last rise", int'(done_o), 1);
        idle(1);
      end else begin
        idle(4);
      end
    end
    if (!pol) sck_i = 1'b0;
    idle(2);
    if (!dtx) begin
      chk(rd_data_o == rx, "R8 slave received byte", int'(rd_data_o), int'(rx));
      last_rx = rx;
    end else begin
      chk(rd_data_o == last_rx, "R10 slave transmit keeps rx data", int'(rd_data_o), int'(last_rx));
    end
    ack();
  endtask

  initial begin
    void'($urandom(32'h1d5e_7a01));
    rst_n = 1'b0;
    en_i = 1'b0; master_i = 1'b0; dir_tx_i = 1'b0; cpol_i = 1'b0; rate_i = 2'd0;
    wr_en_i = 1'b0; wr_data_i = 8'h00; rd_en_i = 1'b0;
    sck_i = 1'b0; sd_i = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(done_o == 1'b0, "R6 reset done", int'(done_o), 0);
    chk(wcol_o == 1'b0, "R7 reset wcol", int'(wcol_o), 0);
    chk(rd_data_o == 8'h00, "R5 reset rx data", int'(rd_data_o), 0);
    chk(sd_oe_o == 1'b0 && sck_oe_o == 1'b0, "R3 disabled outputs off", int'({sd_oe_o, sck_oe_o}), 0);

    master_i = 1'b1; dir_tx_i = 1'b1;
    idle(2);
    chk(sd_oe_o == 1'b0, "R3 disabled master transmit stays off", int'(sd_oe_o), 0);

    // Directed corners: each rate, both polarities, both directions
    master_xfer(2'd0, 1'b0, 1'b1, 8'hA5, 8'h00, 1'b0);
    master_xfer(2'd3, 1'b1, 1'b1, 8'h81, 8'h00, 1'b0);
    master_xfer(2'd1, 1'b1, 1'b0, 8'h00, 8'hC3, 1'b0);
    master_xfer(2'd2, 1'b0, 1'b0, 8'h00, 8'h7E, 1'b0);
    master_xfer(2'd3, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0);
    master_xfer(2'd2, 1'b1, 1'b1, 8'h3C, 8'h00, 1'b1);
    slave_rx(1'b0, 1'b0, 8'h96);
    slave_rx(1'b1, 1'b0, 8'h4B);
    slave_rx(1'b1, 1'b1, 8'h21);

    for (int i = 0; i < 20; i++) begin
      master_xfer(2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
                  1'($urandom_range(1, 0)), 8'($urandom), 8'($urandom),
                  ($urandom_range(3, 0) == 0));
    end

    en_i = 1'b0;
    idle(2);
    chk(sd_oe_o == 1'b0 && sck_oe_o == 1'b0, "R3 outputs off after disable", int'({sd_oe_o, sck_oe_o}), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule